// File: doc/BRIEF.md
# Windowed Relay Power Modulator

This block sets the power of a resistive heater by switching one solid-state relay on and off inside a slow, fixed modulation window. A free-running window counter advances on an external 1 ms tick and wraps every `WINDOW_MS` ticks, which is 1500 by default. At each wrap the block captures an on-time for the next window. The relay is driven high for that many ticks at the start of the window and low for the rest. With the defaults this gives a 1.5 s period and 1500 power steps of about 1 W each on a 1500 W element.

The on-time depends on a 2-bit mode word from the process sequencer:
- **Full power** (ramp phases): the on-time is the whole window.
- **Proportional** (soak phase): the on-time is a gain times the temperature error, limited to a clamp.
- **Any other code**: the relay is forced low in the same cycle, without waiting for the window to end.

The setpoint and the measured temperature arrive as unsigned words. They come already filtered, in whatever units the sequencer uses.

Top module: `relay_window_pwm`

## Requirements
- R1: While `rst_ni` is low, the window counter and the latched on-time are zero and `relay_o` is low. After reset is released, the relay stays low until the first window boundary, because the latched on-time is zero.
- R2: The window counter advances by one only in cycles where `tick_i` is high. It counts from 0 to `WINDOW_MS-1` and wraps to 0. A window boundary is a cycle with `tick_i` high while the counter is at `WINDOW_MS-1`.
- R3: The on-time is captured only at a window boundary. Changing the inputs at any other point has no effect on the current window.
- R4: `relay_o` is high exactly when `mode_i` is full power or proportional and the counter is below the latched on-time.
- R5: Mode `2'b01` (full power) captures an on-time of `WINDOW_MS`. The relay is then high for every tick of the next window.
- R6: Mode `2'b10` (proportional) captures `KP*(setpoint_i-temp_i)`, limited to `CLAMP_MAX`. When `setpoint_i <= temp_i` it captures 0.
- R7: Modes `2'b00` (off) and `2'b11` (halt) drive `relay_o` low combinationally, before the next clock edge. A boundary that falls in these modes captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| mode_i | input | 2 | 00 off, 01 full power, 10 proportional, 11 halt |
| setpoint_i | input | TEMP_W | Target temperature, unsigned |
| temp_i | input | TEMP_W | Measured temperature, unsigned |
| relay_o | output | 1 | Relay enable |

## Verification
The assertions assume that `tick_i` is a single-cycle strobe that is synchronous to `clk_i`. They also assume that `CLAMP_MAX` does not exceed `WINDOW_MS`, so a captured on-time never goes past the window. The bench drives `tick_i` only at falling edges, as a level held for one cycle, and builds with `CLAMP_MAX` below the window length. Every mode code, including the halt code, is applied both at window boundaries and in the middle of a window. In the bench configuration every setpoint and temperature pair is swept, so the error covers the negative, zero, linear and clamped regions.

// File: rtl/relay_pwm_pkg.sv
package relay_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_FULL = 2'b01,
    MODE_PROP = 2'b10,
    MODE_HALT = 2'b11
  } pwr_mode_e;

  function automatic logic mode_drives(pwr_mode_e m);
    return (m == MODE_FULL) || (m == MODE_PROP);
  endfunction

endpackage

// File: rtl/rw_window_timer.sv
module rw_window_timer #(
  parameter int unsigned WINDOW_MS = 1500,
  parameter int unsigned ON_W      = $clog2(WINDOW_MS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [ON_W-1:0] cnt_o,
  output logic            wrap_o
);
  localparam logic [ON_W-1:0] LAST = ON_W'(WINDOW_MS - 1);

  logic [ON_W-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rw_duty_calc.sv
module rw_duty_calc
  import relay_pwm_pkg::*;
#(
  parameter int unsigned TEMP_W    = 12,
  parameter int unsigned WINDOW_MS = 1500,
  parameter int unsigned KP        = 8,
  parameter int unsigned CLAMP_MAX = WINDOW_MS,
  parameter int unsigned ON_W      = $clog2(WINDOW_MS + 1)
) (
  input  pwr_mode_e         mode_i,
  input  logic [TEMP_W-1:0] sp_i,
  input  logic [TEMP_W-1:0] pv_i,
  output logic [ON_W-1:0]   duty_o
);
  localparam int unsigned KP_W   = (KP < 2) ? 1 : $clog2(KP + 1);
  localparam int unsigned PROD_W = TEMP_W + KP_W;
  localparam int unsigned CMP_W  = ((PROD_W > ON_W) ? PROD_W : ON_W) + 1;
  localparam logic [KP_W-1:0]  KP_V  = KP_W'(KP);
  localparam logic [CMP_W-1:0] CLAMP = CMP_W'(CLAMP_MAX);

  logic [TEMP_W:0]    err;
  logic [PROD_W-1:0]  prod;
  logic [CMP_W-1:0]   prod_x;
  logic [ON_W-1:0]    prop_duty;

  assign err    = {1'b0, sp_i} - {1'b0, pv_i};
  // Borrow bit set means sp < pv: no heat.
  assign prod   = err[TEMP_W] ? '0 : PROD_W'(err[TEMP_W-1:0]) * PROD_W'(KP_V);
  assign prod_x = CMP_W'(prod);

  always_comb begin
    if (prod_x > CLAMP) prop_duty = ON_W'(CLAMP_MAX);
    else                prop_duty = ON_W'(prod_x);
  end

  always_comb begin
    unique case (mode_i)
      MODE_FULL: duty_o = ON_W'(WINDOW_MS);
      MODE_PROP: duty_o = prop_duty;
      default:   duty_o = '0;
    endcase
  end
endmodule

// File: rtl/rw_duty_latch.sv
module rw_duty_latch
  import relay_pwm_pkg::*;
#(
  parameter int unsigned ON_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wrap_i,
  input  logic [ON_W-1:0] duty_i,
  input  logic [ON_W-1:0] cnt_i,
  input  pwr_mode_e       mode_i,
  output logic [ON_W-1:0] on_o,
  output logic            relay_o
);
  logic [ON_W-1:0] on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     on_q <= '0;
    else if (wrap_i) on_q <= duty_i;
  end

  assign on_o = on_q;
  // Mode gate is combinational so off/halt cut the relay without waiting.
  assign relay_o = mode_drives(mode_i) && (cnt_i < on_q);
endmodule

// File: rtl/relay_window_pwm.sv
module relay_window_pwm
  import relay_pwm_pkg::*;
#(
  parameter int unsigned TEMP_W    = 12,
  parameter int unsigned WINDOW_MS = 1500,
  parameter int unsigned KP        = 8,
  parameter int unsigned CLAMP_MAX = WINDOW_MS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic [TEMP_W-1:0] setpoint_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              relay_o
);
  localparam int unsigned ON_W = $clog2(WINDOW_MS + 1);

  pwr_mode_e       mode;
  logic [ON_W-1:0] cnt_w;
  logic [ON_W-1:0] on_w;
  logic [ON_W-1:0] duty_w;
  logic            wrap_w;

  assign mode = pwr_mode_e'(mode_i);

  rw_window_timer #(.WINDOW_MS(WINDOW_MS), .ON_W(ON_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  rw_duty_calc #(
    .TEMP_W(TEMP_W), .WINDOW_MS(WINDOW_MS), .KP(KP),
    .CLAMP_MAX(CLAMP_MAX), .ON_W(ON_W)
  ) u_calc (
    .mode_i (mode),
    .sp_i   (setpoint_i),
    .pv_i   (temp_i),
    .duty_o (duty_w)
  );

  rw_duty_latch #(.ON_W(ON_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap_w),
    .duty_i  (duty_w),
    .cnt_i   (cnt_w),
    .mode_i  (mode),
    .on_o    (on_w),
    .relay_o (relay_o)
  );
endmodule

// File: rtl/relay_window_pwm_chk.sv
module relay_window_pwm_chk #(
  parameter int unsigned WINDOW_MS = 1500,
  parameter int unsigned ON_W      = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic [1:0]      mode_i,
  input logic            relay_o,
  input logic [ON_W-1:0] cnt_i,
  input logic [ON_W-1:0] on_i
);
  localparam logic [ON_W-1:0] LAST = ON_W'(WINDOW_MS - 1);
  localparam logic [ON_W-1:0] FULL = ON_W'(WINDOW_MS);

  a_r1_reset_low: assert property (@(posedge clk_i) !rst_ni |-> !relay_o);

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != LAST) |=> cnt_i == $past(cnt_i) + 1'b1);

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == LAST) |=> cnt_i == '0);

  a_r3_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && cnt_i == LAST) |=> $stable(on_i));

  a_r4_on_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_i <= FULL);

  a_r5_full_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == LAST && mode_i == 2'b01) |=> on_i == FULL);

  a_r7_forced_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 || mode_i == 2'b11) |-> !relay_o);

  a_r7_zero_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == LAST && (mode_i == 2'b00 || mode_i == 2'b11)) |=> on_i == '0);
endmodule

bind relay_window_pwm relay_window_pwm_chk #(.WINDOW_MS(WINDOW_MS), .ON_W(ON_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .mode_i  (mode_i),
  .relay_o (relay_o),
  .cnt_i   (cnt_w),
  .on_i    (on_w)
);

// File: tb/tb_relay_window_pwm.sv
`timescale 1ns/1ps
module tb_relay_window_pwm;
  localparam int TW  = 6;
  localparam int WIN = 20;
  localparam int KPV = 3;
  localparam int CLM = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [TW-1:0] sp = '0;
  logic [TW-1:0] pv = '0;
  logic          relay;

  int checks = 0;
  int failures = 0;
  string phase = "R1";
  int m_cnt = 0;
  int m_on = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  relay_window_pwm #(.TEMP_W(TW), .WINDOW_MS(WIN), .KP(KPV), .CLAMP_MAX(CLM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode),
    .setpoint_i(sp), .temp_i(pv), .relay_o(relay)
  );

  function automatic int exp_duty(int md, int s, int p);
    int e;
    e = s - p;
    if (md == 1) return WIN;
    if (md == 2) begin
      if (e <= 0) return 0;
      return (e * KPV > CLM) ? CLM : e * KPV;
    end
    return 0;
  endfunction

  // Requirement model: window counter and captured on-time (R2, R3, R5, R6, R7)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0;
      m_on  <= 0;
    end else if (tick) begin
      if (m_cnt == WIN - 1) begin
        m_cnt <= 0;
        m_on  <= exp_duty(int'(mode), int'(sp), int'(pv));
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(bit got, bit exp, string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s t=%0t relay=%0b expected=%0b", req, $time, got, exp);
    end
  endtask

  // R4: relay high iff driving mode and counter below captured on-time
  always @(negedge clk) begin
    #2;
    if (!done)
      check(relay, rst_n && (mode == 2'b01 || mode == 2'b10) && (m_cnt < m_on), phase);
  end

  task automatic cyc(bit t);
    @(negedge clk);
    tick = t;
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  initial begin
    phase = "R1";
    mode = 2'b01;
    repeat (4) cyc(1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    tick = 1'b1;
    // R1: first window after reset stays low even in full power
    run_ticks(WIN);
    phase = "R5";
    run_ticks(3 * WIN);

    // R2: sparse ticks, counter holds between them
    phase = "R2";
    for (int i = 0; i < 6 * WIN; i++) cyc(($urandom_range(0, 2) == 0));

    // R6: exhaustive setpoint/temperature sweep, one window per pair
    phase = "R6";
    mode = 2'b10;
    for (int s = 0; s < (1 << TW); s++) begin
      for (int p = 0; p < (1 << TW); p++) begin
        @(negedge clk);
        sp = TW'(s);
        pv = TW'(p);
        tick = 1'b1;
        run_ticks(WIN);
      end
    end

    // R3: inputs and mode change mid-window
    phase = "R3";
    for (int i = 0; i < 40 * WIN; i++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 4) == 0) begin
        sp = TW'($urandom_range(0, (1 << TW) - 1));
        pv = TW'($urandom_range(0, (1 << TW) - 1));
      end
      if ($urandom_range(0, 15) == 0) mode = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10;
    end

    // R7: off/halt cut the relay before the next edge
    phase = "R7";
    mode = 2'b01;
    sp = '0; pv = '0;
    run_ticks(2 * WIN + 3);
    @(negedge clk);
    tick = 1'b0;
    mode = 2'b11;
    #1 check(relay, 1'b0, "R7");
    run_ticks(WIN);
    mode = 2'b01;
    run_ticks(5);
    @(negedge clk);
    mode = 2'b00;
    #1 check(relay, 1'b0, "R7");
    for (int i = 0; i < 10 * WIN; i++) begin
      @(negedge clk);
      tick = 1'b1;
      mode = 2'($urandom_range(0, 3));
    end

    // R1: asynchronous reset mid-window
    phase = "R1";
    mode = 2'b01;
    run_ticks(2 * WIN + 4);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(relay, 1'b0, "R1");
    repeat (3) cyc(1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    run_ticks(2 * WIN);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1'b1;
    failures++;
    $display("FAIL watchdog expired relay=%0b expected=finish", relay);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule